// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block arbitrates four interrupt sources for a small 8-bit processor core: two external request pins (active-low, asynchronous), a timer overflow pulse, and a converter overflow that can come from either of two counters. Each source has a request flag and an enable bit. A master enable gates all of them. Software reaches the flags and enables through two 8-bit control registers.

Arbitration happens only on cycles where the core's service strobe is high. At such a cycle, if the master enable is set and the core's stack is not full, the block picks the highest-priority enabled pending source. It then pulses a call strobe for one cycle and presents that source's fixed vector address. When the core acknowledges, the block clears the serviced flag and the master enable. Only an interrupt-return pulse sets the master enable again. A plain return leaves it as it is.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset both control registers read 0x00, and the call strobe is low.
- R2: Register 0 (select 0) holds master enable at bit0, source enables ext0/ext1/timer at bits 1/2/3, and flags ext0/ext1/timer at bits 4/5/6; bit7 reads 0. Register 1 (select 1) holds the converter enable at bit0 and the converter flag at bit4; all other bits read 0.
- R3: Among pending enabled sources, ext0 wins over ext1, ext1 over timer, and timer over converter. The vector addresses are 0x04, 0x08, 0x0C and 0x10 in that same order.
- R4: A call is issued only when the master enable is set, the source's enable bit is set, and stack-full is low. A flag whose enable is clear stays set and is not serviced.
- R5: Requests are evaluated only on a cycle with the service strobe high. The call strobe rises on the following cycle.
- R6: An acknowledge clears the serviced source's flag and the master enable. It leaves the other flags unchanged.
- R7: An interrupt-return pulse sets the master enable. A plain return pulse leaves it unchanged.
- R8: A falling edge on an external request pin sets its flag after a two-flop synchronizer. A rising edge sets nothing.
- R9: A timer overflow pulse sets the timer flag. A pulse on either converter overflow input sets the converter flag.
- R10: If a hardware set and a software write clearing the same flag land in the same cycle, the flag ends up set.
- R11: The call strobe lasts one cycle. No further call is issued until the outstanding one is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = register 0, 1 = register 1 |
| reg_wdata | input | 7 | Write data bits 6:0 (bit7 is reserved in both registers) |
| reg_rdata | output | 8 | Read data of the selected register |
| ext0_n | input | 1 | External request 0, active on falling edge |
| ext1_n | input | 1 | External request 1, active on falling edge |
| tmr_ovf | input | 1 | Timer overflow pulse |
| cnv_ovf_a | input | 1 | Converter counter A overflow pulse |
| cnv_ovf_b | input | 1 | Converter counter B overflow pulse |
| svc_tick | input | 1 | Service phase strobe from the core |
| stack_full | input | 1 | Core stack is full; blocks calls |
| vec_call | output | 1 | One-cycle call request |
| vec_addr | output | 8 | Vector address of the granted source |
| vec_ack | input | 1 | Core acknowledges the call |
| reti | input | 1 | Interrupt-return executed |
| ret_plain | input | 1 | Plain subroutine return executed |

## Verification
Corrupted internal state becomes visible at the ports within one or two cycles. A wrong flag or enable bit appears directly in the register read data. A wrong priority choice shows as a wrong vector address on the cycle after the service strobe. A master enable that is not cleared, or an outstanding-call marker that is lost, shows as a second call strobe while the first is still unacknowledged. That second strobe comes on the next service-strobe cycle. Synchronizer faults show as a flag that appears too early, never appears, or appears on a rising edge. The bench checks these by reading both registers back several cycles after each pin stimulus.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NSRC = 4;
  localparam int IDXW = $clog2(NSRC);
  localparam int AW   = 8;

  // Vector spacing of four words starting at 0x04, in priority order.
  function automatic logic [AW-1:0] vec_of(input logic [IDXW-1:0] idx);
    return AW'({idx, 2'b00}) + AW'(4);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
`timescale 1ns/1ps
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  // sr[STAGES-1] is the synchronized level, sr[STAGES] its previous value.
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-1:0], pin_n};
  end

  assign fall = sr[STAGES] & ~sr[STAGES-1];
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end

  always_comb begin
    assert_grant_onehot_R3: assert ($onehot0(grant));
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic          reg_sel,
  input  logic [6:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          ext0_n,
  input  logic          ext1_n,
  input  logic          tmr_ovf,
  input  logic          cnv_ovf_a,
  input  logic          cnv_ovf_b,
  input  logic          svc_tick,
  input  logic          stack_full,
  output logic          vec_call,
  output logic [AW-1:0] vec_addr,
  input  logic          vec_ack,
  input  logic          reti,
  input  logic          ret_plain
);
  // Source index order is priority order: 0 ext0, 1 ext1, 2 timer, 3 converter.
  logic [NSRC-1:0] flag_q, flag_d, en_q, en_d, hw_set, req, grant;
  logic            mem_q, mem_d, busy_q, any_req, launch, ack_hit, wr0, wr1;
  logic [IDXW-1:0] src_q, pick;
  logic [1:0]      ext_n, ext_fall;

  assign ext_n = {ext1_n, ext0_n};

  for (genvar g = 0; g < 2; g++) begin : g_ext
    irq_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst(rst), .pin_n(ext_n[g]), .fall(ext_fall[g])
    );
  end

  assign hw_set  = {cnv_ovf_a | cnv_ovf_b, tmr_ovf, ext_fall};
  assign wr0     = reg_wr_en & ~reg_sel;
  assign wr1     = reg_wr_en &  reg_sel;
  assign ack_hit = vec_ack & busy_q;
  assign req     = flag_q & en_q;

  irq_prio_pick #(.N(NSRC)) pick_i (
    .req(req), .grant(grant), .any(any_req), .idx(pick)
  );

  assign launch = svc_tick & mem_q & ~stack_full & ~busy_q & any_req;

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    if (wr0) begin
      en_d[2:0]   = reg_wdata[3:1];
      flag_d[2:0] = reg_wdata[6:4];
    end
    if (wr1) begin
      en_d[3]   = reg_wdata[0];
      flag_d[3] = reg_wdata[4];
    end
    if (ack_hit) flag_d[src_q] = 1'b0;
    flag_d = flag_d | hw_set;         // hardware set wins
  end

  always_comb begin
    if (ack_hit)   mem_d = 1'b0;
    else if (reti) mem_d = 1'b1;
    else if (wr0)  mem_d = reg_wdata[0];
    else           mem_d = mem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= '0;
      en_q     <= '0;
      mem_q    <= 1'b0;
      busy_q   <= 1'b0;
      src_q    <= '0;
      vec_call <= 1'b0;
      vec_addr <= '0;
    end else begin
      flag_q   <= flag_d;
      en_q     <= en_d;
      mem_q    <= mem_d;
      vec_call <= launch;
      if (launch) begin
        busy_q   <= 1'b1;
        src_q    <= pick;
        vec_addr <= vec_of(pick);
      end else if (ack_hit) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!reg_sel) reg_rdata = {1'b0, flag_q[2:0], en_q[2:0], mem_q};
    else          reg_rdata = {3'b000, flag_q[3], 3'b000, en_q[3]};
  end

  assert_call_gated_R4: assert property (@(posedge clk) disable iff (rst)
    vec_call |-> ($past(mem_q) && !$past(stack_full)));
  assert_call_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    vec_call |-> $past(svc_tick));
  assert_ack_clears_mem_R6: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> !mem_q);
  assert_reti_sets_mem_R7: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack_hit) |=> mem_q);
  assert_plain_ret_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (ret_plain && !reti && !ack_hit && !wr0) |=> $stable(mem_q));
  assert_hw_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set)));
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    vec_call |=> !vec_call);
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 0, reg_sel = 0;
  logic [6:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ext0_n = 1, ext1_n = 1, tmr_ovf = 0, cnv_ovf_a = 0, cnv_ovf_b = 0;
  logic svc_tick = 0, stack_full = 0, vec_ack = 0, reti = 0, ret_plain = 0;
  logic vec_call;
  logic [7:0] vec_addr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext0_n(ext0_n),
    .ext1_n(ext1_n), .tmr_ovf(tmr_ovf), .cnv_ovf_a(cnv_ovf_a),
    .cnv_ovf_b(cnv_ovf_b), .svc_tick(svc_tick), .stack_full(stack_full),
    .vec_call(vec_call), .vec_addr(vec_addr), .vec_ack(vec_ack),
    .reti(reti), .ret_plain(ret_plain)
  );

  // Table entry: {flags[3:0], enables[3:0], expected vector (0 = no call)}.
  localparam int NV = 7;
  localparam logic [15:0] VTAB [NV] = '{
    {4'b1111, 4'b1111, 8'h04},
    {4'b1110, 4'b1111, 8'h08},
    {4'b1100, 4'b1111, 8'h0C},
    {4'b1000, 4'b1111, 8'h10},
    {4'b1111, 4'b1110, 8'h08},
    {4'b1001, 4'b1110, 8'h10},
    {4'b0101, 4'b1010, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [6:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr_en = 1;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [3:0] f, e;
    logic [7:0] ex;
    int ncall;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 reg0", d, 8'h00);
    rd(1, d); chk("R1 reg1", d, 8'h00);
    chk("R1 call", vec_call, 0);

    // R2 layout and reserved bits
    wr(0, 7'h7E); rd(0, d); chk("R2 reg0", d, 8'h7E);
    wr(1, 7'h7F); rd(1, d); chk("R2 reg1", d, 8'h11);
    wr(0, 7'h00); wr(1, 7'h00);

    // R3/R4 vector table
    for (int k = 0; k < NV; k++) begin
      f = VTAB[k][15:12]; e = VTAB[k][11:8]; ex = VTAB[k][7:0];
      wr(1, {2'b00, f[3], 3'b000, e[3]});
      wr(0, {f[2:0], e[2:0], 1'b1});
      svc_tick = 1;
      @(negedge clk);
      svc_tick = 0;
      chk($sformatf("R3 call row%0d", k), vec_call, ex != 0);
      if (ex != 0) begin
        chk($sformatf("R3 vector row%0d", k), vec_addr, ex);
        vec_ack = 1;
        @(negedge clk);
        vec_ack = 0;
        f[(ex >> 2) - 1] = 1'b0;
        rd(0, d); chk($sformatf("R6 reg0 row%0d", k), d, {1'b0, f[2:0], e[2:0], 1'b0});
        rd(1, d); chk($sformatf("R6 reg1 row%0d", k), d, {3'b0, f[3], 3'b0, e[3]});
      end else begin
        rd(0, d); chk("R4 disabled flags kept", d, {1'b0, f[2:0], e[2:0], 1'b1});
      end
      wr(0, 7'h00); wr(1, 7'h00);
    end

    // R5: no evaluation without the service strobe
    wr(0, 7'h13);                       // ext0 flag, ext0 en, master
    ncall = 0;
    repeat (4) begin @(negedge clk); if (vec_call) ncall++; end
    chk("R5 no call without tick", ncall, 0);
    // R4: stack full blocks
    stack_full = 1; svc_tick = 1;
    @(negedge clk);
    svc_tick = 0;
    @(negedge clk);
    chk("R4 stack full blocks", vec_call, 0);
    stack_full = 0;
    // R4: master off blocks
    wr(0, 7'h12);
    svc_tick = 1; @(negedge clk); svc_tick = 0;
    chk("R4 master off blocks", vec_call, 0);
    rd(0, d); chk("R4 flag retained", d, 8'h12);

    // R11 one call outstanding, R5 rises after tick
    wr(0, 7'h13);
    svc_tick = 1;
    ncall = 0;
    repeat (5) begin @(negedge clk); if (vec_call) ncall++; end
    chk("R11 single call while unacked", ncall, 1);
    chk("R11 vector held", vec_addr, 8'h04);
    svc_tick = 0; vec_ack = 1;
    @(negedge clk);
    vec_ack = 0;
    rd(0, d); chk("R6 master cleared", d, 8'h02);

    // R7 plain return vs interrupt return
    ret_plain = 1; @(negedge clk); ret_plain = 0;
    rd(0, d); chk("R7 plain return keeps", d, 8'h02);
    reti = 1; @(negedge clk); reti = 0;
    rd(0, d); chk("R7 reti sets", d, 8'h03);
    wr(0, 7'h00);

    // R8 external falling edges through synchronizer
    ext0_n = 0; repeat (5) @(negedge clk);
    rd(0, d); chk("R8 ext0 fall", d, 8'h10);
    wr(0, 7'h00);
    ext0_n = 1; repeat (5) @(negedge clk);
    rd(0, d); chk("R8 rise ignored", d, 8'h00);
    ext1_n = 0; repeat (5) @(negedge clk);
    rd(0, d); chk("R8 ext1 fall", d, 8'h20);
    ext1_n = 1; wr(0, 7'h00);

    // R9 timer and converter sources
    tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
    rd(0, d); chk("R9 timer flag", d, 8'h40);
    wr(0, 7'h00);
    cnv_ovf_a = 1; @(negedge clk); cnv_ovf_a = 0;
    rd(1, d); chk("R9 converter A", d, 8'h10);
    wr(1, 7'h00);
    cnv_ovf_b = 1; @(negedge clk); cnv_ovf_b = 0;
    rd(1, d); chk("R9 converter B", d, 8'h10);
    wr(1, 7'h00);

    // R10 hardware set beats software clear
    wr(0, 7'h40);
    @(negedge clk);
    reg_sel = 0; reg_wdata = 7'h00; reg_wr_en = 1; tmr_ovf = 1;
    @(negedge clk);
    reg_wr_en = 0; tmr_ovf = 0;
    rd(0, d); chk("R10 set wins", d, 8'h40);

    finish_run();
  end
endmodule